// File: doc/BRIEF.md
# Fault Versus Output Error Classifier

This block sits in a measurement harness around a pipelined circuit that carries shadow-register timing monitors. Each monitor raises a fault flag in the cycle it sees a discrepancy, but the monitors sit at different depths of the pipeline. A fault at a given monitor only reaches the circuit's output some cycles later. The block delays each monitor's flag by a per-monitor latency so that all flags line up with the output sample they could have corrupted. The aligned flags are then OR-combined into one indication.

Each cycle, the combined aligned indication is compared with an output-error bit supplied by the harness. The cycle is sorted into one of four classes: a detected fault (flag and error), a false fault (flag without error), a missed fault (error without flag) or clean (neither). One saturating counter per class accumulates the tally while a run-enable input is high. A synchronous clear empties the counters and the delay pipelines between measurement points, for example between two clock frequencies of a sweep.

Top module: `fault_align_classifier`

## Requirements
- R1: After reset, all four counters read zero, the class output reads 0 (clean) and every delay pipeline is empty.
- R2: A flag raised by monitor m in cycle t counts as aligned in cycle t+L, where L is that monitor's latency field `lat_cfg[m*LAT_W +: LAT_W]`. L = 0 aligns the flag in the same cycle.
- R3: A latency field above MAX_LAT is treated as MAX_LAT.
- R4: The aligned flags of all monitors are OR-combined. Several monitors aligned in one cycle still classify that cycle only once.
- R5: A cycle with an aligned flag and `out_err` high is a detected fault. It increments `cnt_detected` and sets the class output to code 1 in the next cycle.
- R6: A cycle with an aligned flag and `out_err` low is a false fault. It increments `cnt_false` and sets the class code to 2.
- R7: A cycle with `out_err` high and no aligned flag is a missed fault. It increments `cnt_missed` and sets the class code to 3.
- R8: A cycle with neither an aligned flag nor `out_err` is clean. It increments `cnt_clean` and sets the class code to 0.
- R9: While `run_en` is low, no counter changes. The class output and the delay pipelines keep updating.
- R10: A counter at its all-ones value stays there when its class occurs again.
- R11: `clear` is synchronous and wins over `run_en`. In the next cycle all counters read zero and the class code reads 0. Flags already inside the delay pipelines are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Synchronous clear of counters, class and delay pipelines |
| run_en | input | 1 | Counting enable |
| fault_flags | input | NUM_MON | One fault flag per monitor |
| out_err | input | 1 | Output sample of this cycle is wrong |
| lat_cfg | input | NUM_MON*LAT_W | Packed per-monitor latencies, monitor m at bits m*LAT_W |
| class_o | output | 2 | Class of the previous cycle: 0 clean, 1 detected, 2 false, 3 missed |
| cnt_clean | output | CNT_W | Clean cycle count |
| cnt_detected | output | CNT_W | Detected fault count |
| cnt_false | output | CNT_W | False fault count |
| cnt_missed | output | CNT_W | Missed fault count |

## Verification
The assertions assume that `lat_cfg` is held steady while flags are in flight. A latency change would re-index the pipelines and re-time flags that are already stored. They also assume that `out_err` refers to the same output sample as the aligned flags in that cycle.

The stimulus changes latencies only in cycles where it also asserts `clear`, or while the pipelines hold no flags. It drives `out_err` directly as the harness would after its golden comparison. The bench's model keeps its own flag history per monitor to predict alignment across the whole latency range, including the clamped values above MAX_LAT.

// File: rtl/fac_pkg.sv
package fac_pkg;

    typedef enum logic [1:0] {
        CLS_CLEAN    = 2'd0,
        CLS_DETECTED = 2'd1,
        CLS_FALSE    = 2'd2,
        CLS_MISSED   = 2'd3
    } fac_class_e;

    localparam int NUM_CLASSES = 4;

    function automatic fac_class_e fac_classify(input logic flagged, input logic err);
        fac_class_e c;
        unique case ({flagged, err})
            2'b11:   c = CLS_DETECTED;
            2'b10:   c = CLS_FALSE;
            2'b01:   c = CLS_MISSED;
            default: c = CLS_CLEAN;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/fac_delay_line.sv
module fac_delay_line #(
    parameter int MAX_LAT = 8,
    parameter int LAT_W   = $clog2(MAX_LAT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             flag_i,
    input  logic [LAT_W-1:0] lat_i,
    output logic             aligned_o
);
    // hist bit k holds the flag seen k cycles ago (bit 0 is the live flag)
    logic [MAX_LAT-1:0] sr_d, sr_q;
    logic [MAX_LAT:0]   hist;
    logic [LAT_W-1:0]   eff_lat;

    generate
        if (MAX_LAT == 1) begin : g_single
            always_comb sr_d = clr ? 1'b0 : flag_i;
        end else begin : g_chain
            always_comb sr_d = clr ? '0 : {sr_q[MAX_LAT-2:0], flag_i};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= sr_d;
    end

    always_comb begin
        hist    = {sr_q, flag_i};
        eff_lat = (lat_i > LAT_W'(MAX_LAT)) ? LAT_W'(MAX_LAT) : lat_i;
        aligned_o = hist[eff_lat];
    end

    AST_FLUSHED_AFTER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (sr_q == '0)) else $error("delay line not flushed"); // R11

endmodule

// File: rtl/fac_sat_counter.sv
module fac_sat_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)                        cnt_d = '0;
        else if (inc && cnt_q != CNT_MAX) cnt_d = cnt_q + CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;

    AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clr && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX)) else $error("counter wrapped"); // R10
    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc && !clr) |=> $stable(cnt_q)) else $error("counter moved without increment"); // R9

endmodule

// File: rtl/fault_align_classifier.sv
module fault_align_classifier
    import fac_pkg::*;
#(
    parameter int NUM_MON = 4,
    parameter int MAX_LAT = 8,
    parameter int CNT_W   = 16,
    parameter int LAT_W   = $clog2(MAX_LAT + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clear,
    input  logic                     run_en,
    input  logic [NUM_MON-1:0]       fault_flags,
    input  logic                     out_err,
    input  logic [NUM_MON*LAT_W-1:0] lat_cfg,
    output logic [1:0]               class_o,
    output logic [CNT_W-1:0]         cnt_clean,
    output logic [CNT_W-1:0]         cnt_detected,
    output logic [CNT_W-1:0]         cnt_false,
    output logic [CNT_W-1:0]         cnt_missed
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        fac_class_e cls;
    } state_t;

    state_t st_d, st_q;

    logic [NUM_MON-1:0]     aligned;
    logic                   any_aligned;
    logic [NUM_CLASSES-1:0] inc;
    logic [CNT_W-1:0]       cnt_w [NUM_CLASSES];

    // one delay pipeline per monitor
    generate
        for (genvar m = 0; m < NUM_MON; m++) begin : g_mon
            fac_delay_line #(
                .MAX_LAT (MAX_LAT),
                .LAT_W   (LAT_W)
            ) dly_i (
                .clk       (clk),
                .rst_n     (rst_n),
                .clr       (clear),
                .flag_i    (fault_flags[m]),
                .lat_i     (lat_cfg[m*LAT_W +: LAT_W]),
                .aligned_o (aligned[m])
            );
        end
    endgenerate

    assign any_aligned = |aligned;

    always_comb begin
        st_d = st_q;
        inc  = '0;
        if (clear) begin
            st_d.cls = CLS_CLEAN;
        end else begin
            st_d.cls = fac_classify(any_aligned, out_err);
            if (run_en) inc[st_d.cls] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{cls: CLS_CLEAN};
        else        st_q <= st_d;
    end

    // one saturating counter per class, indexed by class code
    generate
        for (genvar c = 0; c < NUM_CLASSES; c++) begin : g_cnt
            fac_sat_counter #(.CNT_W(CNT_W)) cnt_i (
                .clk   (clk),
                .rst_n (rst_n),
                .clr   (clear),
                .inc   (inc[c]),
                .cnt_o (cnt_w[c])
            );
        end
    endgenerate

    assign class_o      = st_q.cls;
    assign cnt_clean    = cnt_w[CLS_CLEAN];
    assign cnt_detected = cnt_w[CLS_DETECTED];
    assign cnt_false    = cnt_w[CLS_FALSE];
    assign cnt_missed   = cnt_w[CLS_MISSED];

    AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (cnt_clean == '0 && cnt_detected == '0 && cnt_false == '0
                   && cnt_missed == '0 && class_o == 2'd0)) else $error("clear incomplete"); // R11
    AST_RUN_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && !clear) |=> ($stable(cnt_clean) && $stable(cnt_detected)
                                 && $stable(cnt_false) && $stable(cnt_missed))) else $error("counted while halted"); // R9
    AST_DETECT_INC: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && !clear && any_aligned && out_err && cnt_detected != CNT_MAX)
        |=> (cnt_detected == $past(cnt_detected) + CNT_W'(1))) else $error("detected not counted"); // R5
    AST_MISSED_INC: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && !clear && !any_aligned && out_err && cnt_missed != CNT_MAX)
        |=> (cnt_missed == $past(cnt_missed) + CNT_W'(1))) else $error("missed not counted"); // R7
    AST_SINGLE_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ($countones({cnt_clean != $past(cnt_clean), cnt_detected != $past(cnt_detected),
                              cnt_false != $past(cnt_false), cnt_missed != $past(cnt_missed)}) <= 1
                  || $past(clear))) else $error("cycle counted twice"); // R4

endmodule

// File: tb/fault_align_classifier_tb_top.sv
`timescale 1ns/1ps
module fault_align_classifier_tb_top;
    localparam int NM    = 3;
    localparam int MAXL  = 5;
    localparam int CW    = 4;
    localparam int LW    = 3;
    localparam int CMAX  = (1 << CW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clear = 1'b0, run_en = 1'b0, out_err = 1'b0;
    logic [NM-1:0] fault_flags = '0;
    logic [NM*LW-1:0] lat_cfg = '0;
    logic [1:0] class_o;
    logic [CW-1:0] cnt_clean, cnt_detected, cnt_false, cnt_missed;

    int tests = 0, fails = 0;
    int lat_m [NM];
    logic hist [NM][MAXL+1];
    int exp_cnt [4];
    int exp_cls;

    always #4 clk = ~clk;

    fault_align_classifier #(.NUM_MON(NM), .MAX_LAT(MAXL), .CNT_W(CW), .LAT_W(LW)) dut_i (
        .clk(clk), .rst_n(rst_n), .clear(clear), .run_en(run_en),
        .fault_flags(fault_flags), .out_err(out_err), .lat_cfg(lat_cfg),
        .class_o(class_o), .cnt_clean(cnt_clean), .cnt_detected(cnt_detected),
        .cnt_false(cnt_false), .cnt_missed(cnt_missed));

    task automatic summary;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    task automatic model_clear;
        for (int m = 0; m < NM; m++)
            for (int k = 0; k <= MAXL; k++) hist[m][k] = 1'b0;
        for (int c = 0; c < 4; c++) exp_cnt[c] = 0;
        exp_cls = 0;
    endtask

    task automatic set_lat(input int m, input int v);
        lat_m[m] = v;
        lat_cfg[m*LW +: LW] = LW'(v);
    endtask

    task automatic compare(input string tag);
        tests++;
        if (class_o != 2'(exp_cls) || cnt_clean != CW'(exp_cnt[0]) || cnt_detected != CW'(exp_cnt[1])
            || cnt_false != CW'(exp_cnt[2]) || cnt_missed != CW'(exp_cnt[3])) begin
            fails++;
            $display("FAIL %s: got cls=%0d clean=%0d det=%0d false=%0d miss=%0d exp cls=%0d clean=%0d det=%0d false=%0d miss=%0d",
                     tag, class_o, cnt_clean, cnt_detected, cnt_false, cnt_missed,
                     exp_cls, exp_cnt[0], exp_cnt[1], exp_cnt[2], exp_cnt[3]);
        end
    endtask

    // one cycle: drive at negedge, model the edge, compare after it
    task automatic step(input logic [NM-1:0] f, input logic e, input logic r, input logic c,
                        input string tag);
        logic al;
        int cls;
        @(negedge clk);
        fault_flags = f; out_err = e; run_en = r; clear = c;
        al = 1'b0;
        for (int m = 0; m < NM; m++) begin
            int eff;
            eff = (lat_m[m] > MAXL) ? MAXL : lat_m[m];
            al = al | ((eff == 0) ? f[m] : hist[m][eff]);
        end
        cls = (al && e) ? 1 : (al ? 2 : (e ? 3 : 0));
        @(posedge clk);
        #1;
        if (c) model_clear();
        else begin
            for (int m = 0; m < NM; m++) begin
                for (int k = MAXL; k >= 2; k--) hist[m][k] = hist[m][k-1];
                hist[m][1] = f[m];
            end
            exp_cls = cls;
            if (r && exp_cnt[cls] < CMAX) exp_cnt[cls]++;
        end
        compare(tag);
    endtask

    initial begin
        for (int m = 0; m < NM; m++) set_lat(m, 0);
        model_clear();
        repeat (3) @(posedge clk);
        #1;
        compare("R1 reset");
        @(negedge clk) rst_n = 1'b1;
        #1 compare("R1 after release");

        // R2: each monitor alone, every in-range latency, error placed at the aligned cycle
        for (int m = 0; m < NM; m++) begin
            for (int l = 0; l <= MAXL; l++) begin
                for (int j = 0; j < NM; j++) set_lat(j, 0);
                set_lat(m, l);
                step('0, 1'b0, 1'b1, 1'b1, "R2 clear");
                step(NM'(1) << m, (l == 0), 1'b1, 1'b0, "R2 pulse");
                for (int k = 1; k <= MAXL + 1; k++)
                    step('0, (k == l), 1'b1, 1'b0, "R2 align R5/R8");
            end
        end

        // R3: latency codes above MAXL behave as MAXL
        for (int l = MAXL + 1; l < (1 << LW); l++) begin
            set_lat(1, l);
            step('0, 1'b0, 1'b1, 1'b1, "R3 clear");
            step(3'b010, 1'b0, 1'b1, 1'b0, "R3 pulse");
            for (int k = 1; k <= MAXL + 1; k++)
                step('0, (k == MAXL), 1'b1, 1'b0, "R3 clamp");
        end

        // R4: distinct latencies, all monitors, flags converging on one cycle
        set_lat(0, 1); set_lat(1, 3); set_lat(2, 5);
        step('0, 1'b0, 1'b1, 1'b1, "R4 clear");
        for (int k = 0; k < 8; k++)
            step({(k == 0), (k == 2), (k == 4)}, 1'b0, 1'b1, 1'b0, "R4 converge R6");

        // R5..R8 random mix, with periodic clear to stay below saturation
        for (int i = 0; i < 600; i++) begin
            logic [NM-1:0] f;
            f = NM'($urandom_range(0, (1 << NM) - 1));
            if ((i % 13) == 0) begin
                for (int m = 0; m < NM; m++) set_lat(m, $urandom_range(0, (1 << LW) - 1));
                step(f, 1'($urandom_range(0, 1)), 1'b1, 1'b1, "R11 periodic clear");
            end else
                step(f & NM'($urandom_range(0, 7)), 1'($urandom_range(0, 1)), 1'b1, 1'b0,
                     "R5/R6/R7/R8 mix");
        end

        // R7: error with no flags at all
        step('0, 1'b0, 1'b1, 1'b1, "R7 clear");
        for (int k = 0; k < 6; k++) step('0, 1'b1, 1'b1, 1'b0, "R7 missed only");

        // R9: run_en low, random stimulus, counters frozen, class still tracks
        for (int i = 0; i < 60; i++)
            step(NM'($urandom_range(0, 7)), 1'($urandom_range(0, 1)), 1'b0, 1'b0, "R9 halted");

        // R10: saturate every class
        set_lat(0, 0); set_lat(1, 0); set_lat(2, 0);
        step('0, 1'b0, 1'b1, 1'b1, "R10 clear");
        for (int k = 0; k < CMAX + 4; k++) step(3'b001, 1'b1, 1'b1, 1'b0, "R10 sat detected");
        for (int k = 0; k < CMAX + 4; k++) step(3'b100, 1'b0, 1'b1, 1'b0, "R10 sat false");
        for (int k = 0; k < CMAX + 4; k++) step('0, 1'b1, 1'b1, 1'b0, "R10 sat missed");
        for (int k = 0; k < CMAX + 4; k++) step('0, 1'b0, 1'b1, 1'b0, "R10 sat clean");

        // R11: clear with flags in flight and run_en high
        set_lat(0, 4); set_lat(1, 2); set_lat(2, 5);
        for (int k = 0; k < 3; k++) step(3'b111, 1'b0, 1'b1, 1'b0, "R11 load");
        step(3'b111, 1'b1, 1'b1, 1'b1, "R11 clear wins");
        for (int k = 0; k < 7; k++) step('0, 1'b0, 1'b1, 1'b0, "R11 flushed");

        summary();
        $finish;
    end
endmodule